// File: doc/BRIEF.md
# JTAG Debug Scan Transaction Monitor

This block watches a stream of completed JTAG scan records and turns them into decoded debug-port transactions. An upstream front end, which has already followed the TAP controller, delivers one record for each finished shift. The record has a type (instruction shift-in, data shift-in or data shift-out), a bit length and a 35-bit captured value whose least significant bit is the last bit listed in the capture. The monitor is passive: it always accepts records, and it never stalls or drives the scan chain.

An instruction shift-in record selects which register the next data scan addresses. The monitor keeps that selection pending until a data record of the matching direction arrives. The bypass register is decoded from the incoming bits. Every other register is decoded from the outgoing bits. The monitor then emits one transaction record for a single cycle and forgets the instruction. Depending on the register, the transaction carries the access payload, address, read/write bit and acknowledge class, or the identification fields, or the abort request together with a reserved-bit warning.

Top module: `jtag_dbg_txn_monitor`

## Requirements
- R1: After synchronous reset `rst`, `txn_valid` is 0, no instruction is pending, and `rec_ready` is 1 at all times.
- R2: With no instruction pending, a record of type 1 (data shift-in), 2 (data shift-out) or 3 (spare) produces no transaction and leaves nothing pending.
- R3: A record of type 0 (instruction shift-in) selects a register from bits 3:0 of its value: 1111 bypass, 1110 identification, 1010 debug-port access, 1011 access-port access, 1000 abort. Any other code selects the unknown register, which still waits for a data record.
- R4: While bypass is pending, only a type 1 record is consumed. Type 2 and type 3 records are skipped, and bypass stays pending.
- R5: While identification, debug-port access, access-port access, abort or unknown is pending, only a type 2 record is consumed. Type 1 and type 3 records are skipped, and the selection stays pending.
- R6: A consumed data record raises `txn_valid` for exactly one cycle, starting on the clock edge after the record is accepted. The same edge clears the pending instruction. `txn_kind` is 0 bypass, 1 identification, 2 debug-port access, 3 access-port access, 4 abort, 5 unknown. `txn_raw` and `txn_len` carry the record's value and length.
- R7: For identification, `txn_id_ver` = value[31:28], `txn_id_part` = value[27:12], `txn_id_mfr` = value[11:1] and `txn_id_rsv` = value[0]. For every other kind these fields read 0.
- R8: For debug-port and access-port access, `txn_data` = value[34:3], `txn_addr` = value[2:1] (0 reserved, 1 control/status, 2 select, 3 read buffer), `txn_rnw` = value[0] and `txn_ack` = value[2:0]. For every other kind these fields read 0.
- R9: For access kinds, `txn_ack_cls` is 1 (WAIT) when the acknowledge is 001, 2 (OK/FAULT) when it is 010, and 0 (reserved) for any other code. For every other kind it reads 0.
- R10: For abort, `txn_abort` = value[0], and `txn_warn` is 1 when any of value[31:1] is non-zero. For every other kind both read 0.
- R11: An instruction record that arrives while another instruction is pending replaces the pending instruction. No transaction is emitted for the replaced one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_valid | input | 1 | Scan record present |
| rec_ready | output | 1 | Always 1: the monitor never stalls |
| rec_type | input | 2 | 0 instruction in, 1 data in, 2 data out, 3 spare |
| rec_len | input | 6 | Shift length in bits |
| rec_value | input | 35 | Captured bits, LSB = last bit listed |
| txn_valid | output | 1 | One-cycle transaction strobe |
| txn_kind | output | 3 | Register kind of the transaction |
| txn_len | output | 6 | Length of the consumed record |
| txn_raw | output | 35 | Value of the consumed record |
| txn_data | output | 32 | Access payload |
| txn_addr | output | 2 | Access register address |
| txn_rnw | output | 1 | Access read (1) or write (0) |
| txn_ack | output | 3 | Raw acknowledge code |
| txn_ack_cls | output | 2 | Acknowledge class |
| txn_id_ver | output | 4 | Identification version |
| txn_id_part | output | 16 | Identification part number |
| txn_id_mfr | output | 11 | Identification manufacturer code |
| txn_id_rsv | output | 1 | Identification bit 0 |
| txn_abort | output | 1 | Abort request bit |
| txn_warn | output | 1 | Abort reserved bits set |

## Verification
Directed sequences come first. They pair each instruction code with both data directions, which separates the shift-in consumer (bypass) from the shift-out consumers. They place an instruction record between an instruction and its data to expose replacement, and they send acknowledge codes 000 to 111 to separate the three classes. After that, a long random stream mixes all four record types. Instruction codes are biased toward the listed encodings, and abort payloads with clean and dirty reserved bits are both generated. The bench keeps a behavioural model and compares every output field on every cycle. A wrongly skipped or wrongly consumed record therefore shows up as a spurious or missing strobe, and a mis-sliced field shows up on its own port.

// File: rtl/jdm_pkg.sv
package jdm_pkg;

    localparam int REC_VAL_W  = 35;
    localparam int CODE_W     = 4;
    localparam int ACK_W      = 3;
    localparam int PAYLOAD_W  = REC_VAL_W - ACK_W;

    typedef enum logic [1:0] {
        REC_IR_IN  = 2'd0,
        REC_DR_IN  = 2'd1,
        REC_DR_OUT = 2'd2,
        REC_SPARE  = 2'd3
    } rec_e;

    typedef enum logic [2:0] {
        MD_IDLE, MD_BYPASS, MD_IDCODE, MD_DPACC, MD_APACC, MD_ABORT, MD_UNKNOWN
    } mode_e;

    typedef enum logic [2:0] {
        TK_BYPASS  = 3'd0,
        TK_IDCODE  = 3'd1,
        TK_DPACC   = 3'd2,
        TK_APACC   = 3'd3,
        TK_ABORT   = 3'd4,
        TK_UNKNOWN = 3'd5
    } txn_kind_e;

    typedef enum logic [1:0] {
        ACK_RSVD  = 2'd0,
        ACK_WAIT  = 2'd1,
        ACK_OKFLT = 2'd2
    } ack_cls_e;

    typedef struct packed {
        txn_kind_e              kind;
        logic [PAYLOAD_W-1:0]   data;
        logic [1:0]             addr;
        logic                   rnw;
        logic [ACK_W-1:0]       ack;
        ack_cls_e               ack_cls;
        logic [3:0]             id_ver;
        logic [15:0]            id_part;
        logic [10:0]            id_mfr;
        logic                   id_rsv;
        logic                   abort_req;
        logic                   rsvd_warn;
    } txn_t;

    function automatic mode_e code_to_mode(input logic [CODE_W-1:0] c);
        case (c)
            4'b1111: return MD_BYPASS;
            4'b1110: return MD_IDCODE;
            4'b1010: return MD_DPACC;
            4'b1011: return MD_APACC;
            4'b1000: return MD_ABORT;
            default: return MD_UNKNOWN;
        endcase
    endfunction

    function automatic rec_e wanted_rec(input mode_e m);
        return (m == MD_BYPASS) ? REC_DR_IN : REC_DR_OUT;
    endfunction

    function automatic ack_cls_e classify_ack(input logic [ACK_W-1:0] a);
        case (a)
            3'b001:  return ACK_WAIT;
            3'b010:  return ACK_OKFLT;
            default: return ACK_RSVD;
        endcase
    endfunction

    function automatic txn_kind_e mode_to_kind(input mode_e m);
        case (m)
            MD_BYPASS: return TK_BYPASS;
            MD_IDCODE: return TK_IDCODE;
            MD_DPACC:  return TK_DPACC;
            MD_APACC:  return TK_APACC;
            MD_ABORT:  return TK_ABORT;
            default:   return TK_UNKNOWN;
        endcase
    endfunction

endpackage

// File: rtl/jdm_mode_tracker.sv
module jdm_mode_tracker
    import jdm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  rec_e                in_type,
    input  logic [CODE_W-1:0]   in_code,
    output mode_e               mode,
    output logic                consume
);

    mode_e mode_q, mode_d;

    assign consume = in_valid && (mode_q != MD_IDLE) && (in_type == wanted_rec(mode_q));

    always_comb begin
        mode_d = mode_q;
        if (in_valid) begin
            if (in_type == REC_IR_IN) begin
                mode_d = code_to_mode(in_code);
            end else if (consume) begin
                mode_d = MD_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MD_IDLE;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign mode = mode_q;

    assert_idle_ignore_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MD_IDLE && in_valid && in_type != REC_IR_IN) |=> (mode_q == MD_IDLE));

    assert_instr_pending_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_type == REC_IR_IN) |=> (mode_q != MD_IDLE));

    assert_skip_keeps_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_q != MD_IDLE && mode_q != MD_BYPASS && in_valid && in_type == REC_DR_IN)
        |=> (mode_q == $past(mode_q)));

    assert_back_to_idle_R6: assert property (@(posedge clk) disable iff (rst)
        consume |=> (mode_q == MD_IDLE));

endmodule

// File: rtl/jdm_field_split.sv
module jdm_field_split
    import jdm_pkg::*;
(
    input  mode_e                   mode,
    input  logic [REC_VAL_W-1:0]    value,
    output txn_t                    txn
);

    always_comb begin
        txn      = '0;
        txn.kind = mode_to_kind(mode);
        case (mode)
            MD_IDCODE: begin
                txn.id_ver  = value[31:28];
                txn.id_part = value[27:12];
                txn.id_mfr  = value[11:1];
                txn.id_rsv  = value[0];
            end
            MD_DPACC, MD_APACC: begin
                txn.data    = value[REC_VAL_W-1:ACK_W];
                txn.addr    = value[2:1];
                txn.rnw     = value[0];
                txn.ack     = value[ACK_W-1:0];
                txn.ack_cls = classify_ack(value[ACK_W-1:0]);
            end
            MD_ABORT: begin
                txn.abort_req = value[0];
                txn.rsvd_warn = |value[31:1];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/jtag_dbg_txn_monitor.sv
module jtag_dbg_txn_monitor
    import jdm_pkg::*;
#(
    parameter int LEN_W = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rec_valid,
    output logic                    rec_ready,
    input  logic [1:0]              rec_type,
    input  logic [LEN_W-1:0]        rec_len,
    input  logic [REC_VAL_W-1:0]    rec_value,
    output logic                    txn_valid,
    output logic [2:0]              txn_kind,
    output logic [LEN_W-1:0]        txn_len,
    output logic [REC_VAL_W-1:0]    txn_raw,
    output logic [PAYLOAD_W-1:0]    txn_data,
    output logic [1:0]              txn_addr,
    output logic                    txn_rnw,
    output logic [ACK_W-1:0]        txn_ack,
    output logic [1:0]              txn_ack_cls,
    output logic [3:0]              txn_id_ver,
    output logic [15:0]             txn_id_part,
    output logic [10:0]             txn_id_mfr,
    output logic                    txn_id_rsv,
    output logic                    txn_abort,
    output logic                    txn_warn
);

    mode_e  mode;
    logic   consume;
    txn_t   txn_d, txn_q;
    logic   valid_q;
    logic [LEN_W-1:0]     len_q;
    logic [REC_VAL_W-1:0] raw_q;

    assign rec_ready = 1'b1;

    jdm_mode_tracker u_track (
        .clk      (clk),
        .rst      (rst),
        .in_valid (rec_valid),
        .in_type  (rec_e'(rec_type)),
        .in_code  (rec_value[CODE_W-1:0]),
        .mode     (mode),
        .consume  (consume)
    );

    jdm_field_split u_split (
        .mode  (mode),
        .value (rec_value),
        .txn   (txn_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            txn_q   <= '0;
            len_q   <= '0;
            raw_q   <= '0;
        end else begin
            valid_q <= consume;
            if (consume) begin
                txn_q <= txn_d;
                len_q <= rec_len;
                raw_q <= rec_value;
            end
        end
    end

    assign txn_valid   = valid_q;
    assign txn_kind    = txn_q.kind;
    assign txn_len     = len_q;
    assign txn_raw     = raw_q;
    assign txn_data    = txn_q.data;
    assign txn_addr    = txn_q.addr;
    assign txn_rnw     = txn_q.rnw;
    assign txn_ack     = txn_q.ack;
    assign txn_ack_cls = txn_q.ack_cls;
    assign txn_id_ver  = txn_q.id_ver;
    assign txn_id_part = txn_q.id_part;
    assign txn_id_mfr  = txn_q.id_mfr;
    assign txn_id_rsv  = txn_q.id_rsv;
    assign txn_abort   = txn_q.abort_req;
    assign txn_warn    = txn_q.rsvd_warn;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !txn_valid);

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        txn_valid |=> !txn_valid);

    assert_warn_only_abort_R10: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && txn_warn) |-> (txn_kind == TK_ABORT));

    assert_wait_class_R9: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && (txn_kind == TK_DPACC || txn_kind == TK_APACC) && txn_ack == 3'b001)
        |-> (txn_ack_cls == ACK_WAIT));

    assert_raw_matches_R8: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && txn_kind == TK_APACC) |-> (txn_raw[2:0] == txn_ack));

endmodule

// File: tb/tb_jtag_dbg_txn_monitor.sv
module tb_jtag_dbg_txn_monitor;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rec_valid = 1'b0;
    logic        rec_ready;
    logic [1:0]  rec_type = 2'd0;
    logic [5:0]  rec_len = 6'd0;
    logic [34:0] rec_value = '0;
    logic        txn_valid;
    logic [2:0]  txn_kind;
    logic [5:0]  txn_len;
    logic [34:0] txn_raw;
    logic [31:0] txn_data;
    logic [1:0]  txn_addr;
    logic        txn_rnw;
    logic [2:0]  txn_ack;
    logic [1:0]  txn_ack_cls;
    logic [3:0]  txn_id_ver;
    logic [15:0] txn_id_part;
    logic [10:0] txn_id_mfr;
    logic        txn_id_rsv;
    logic        txn_abort;
    logic        txn_warn;

    int checks = 0;
    int errors = 0;
    int mstate = 0;  // 0 idle,1 bypass,2 id,3 dp,4 ap,5 abort,6 unknown

    always #10 clk = ~clk;

    jtag_dbg_txn_monitor dut (
        .clk(clk), .rst(rst), .rec_valid(rec_valid), .rec_ready(rec_ready),
        .rec_type(rec_type), .rec_len(rec_len), .rec_value(rec_value),
        .txn_valid(txn_valid), .txn_kind(txn_kind), .txn_len(txn_len),
        .txn_raw(txn_raw), .txn_data(txn_data), .txn_addr(txn_addr),
        .txn_rnw(txn_rnw), .txn_ack(txn_ack), .txn_ack_cls(txn_ack_cls),
        .txn_id_ver(txn_id_ver), .txn_id_part(txn_id_part),
        .txn_id_mfr(txn_id_mfr), .txn_id_rsv(txn_id_rsv),
        .txn_abort(txn_abort), .txn_warn(txn_warn)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp(input string tag, input longint act, input longint exp);
        chk(act == exp, tag, act, exp);
    endtask

    function automatic int instr_state(input int code);
        case (code)
            15: return 1;
            14: return 2;
            10: return 3;
            11: return 4;
            8:  return 5;
            default: return 6;
        endcase
    endfunction

    // Drive one cycle; model predicts outputs after the next rising edge.
    task automatic step(input bit v, input int typ, input longint val, input int len);
        bit      e_valid;
        int      e_kind;
        longint  e_data, e_addr, e_rnw, e_ack, e_cls, e_ver, e_part, e_mfr, e_rsv, e_abt, e_warn;
        int      want;
        rec_valid = v;
        rec_type  = typ[1:0];
        rec_value = val[34:0];
        rec_len   = len[5:0];
        e_valid = 0;
        e_kind = 0;
        {e_data, e_addr, e_rnw, e_ack, e_cls, e_ver, e_part, e_mfr, e_rsv, e_abt, e_warn} = '0;
        want = (mstate == 1) ? 1 : 2;
        if (v) begin
            if (typ == 0) begin
                mstate = instr_state(int'(val & 15));           // R3, R11
            end else if (mstate != 0 && typ == want) begin      // R4, R5
                e_valid = 1;
                e_kind  = mstate - 1;
                if (mstate == 2) begin                          // R7
                    e_ver  = (val >> 28) & 15;
                    e_part = (val >> 12) & 16'hFFFF;
                    e_mfr  = (val >> 1) & 11'h7FF;
                    e_rsv  = val & 1;
                end
                if (mstate == 3 || mstate == 4) begin           // R8, R9
                    e_data = (val >> 3) & 32'hFFFF_FFFF;
                    e_addr = (val >> 1) & 3;
                    e_rnw  = val & 1;
                    e_ack  = val & 7;
                    e_cls  = (e_ack == 1) ? 1 : (e_ack == 2) ? 2 : 0;
                end
                if (mstate == 5) begin                          // R10
                    e_abt  = val & 1;
                    e_warn = (((val >> 1) & 32'h7FFF_FFFF) != 0) ? 1 : 0;
                end
                mstate = 0;                                     // R6
            end
        end
        @(posedge clk);
        @(negedge clk);
        cmp("R6 txn_valid", txn_valid, e_valid);
        cmp("R1 rec_ready", rec_ready, 1);
        if (e_valid) begin
            cmp("R6 txn_kind", txn_kind, e_kind);
            cmp("R6 txn_raw", txn_raw, val & 35'h7_FFFF_FFFF);
            cmp("R6 txn_len", txn_len, len & 63);
            cmp("R7 id_ver", txn_id_ver, e_ver);
            cmp("R7 id_part", txn_id_part, e_part);
            cmp("R7 id_mfr", txn_id_mfr, e_mfr);
            cmp("R7 id_rsv", txn_id_rsv, e_rsv);
            cmp("R8 data", txn_data, e_data);
            cmp("R8 addr", txn_addr, e_addr);
            cmp("R8 rnw", txn_rnw, e_rnw);
            cmp("R8 ack", txn_ack, e_ack);
            cmp("R9 ack_cls", txn_ack_cls, e_cls);
            cmp("R10 abort", txn_abort, e_abt);
            cmp("R10 warn", txn_warn, e_warn);
        end
    endtask

    task automatic idle_cycle();
        step(0, 0, 0, 0);
    endtask

    longint rv;

    initial begin
        fork
            begin
                #4_000_000;
                errors++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        join_none

        repeat (3) @(posedge clk);
        @(negedge clk);
        cmp("R1 txn_valid in reset", txn_valid, 0);
        rst = 1'b0;
        idle_cycle();

        // R2: data and spare records with nothing pending
        step(1, 1, 35'h1234, 35);
        step(1, 2, 35'h5678, 35);
        step(1, 3, 35'h0F, 4);
        // R4: bypass ignores shift-out, consumes shift-in
        step(1, 0, 35'hF, 4);
        step(1, 2, 35'h3, 1);
        step(1, 3, 35'h3, 1);
        step(1, 1, 35'h1, 1);
        // R5, R7: identification
        step(1, 0, 35'hE, 4);
        step(1, 1, 35'h1111, 32);
        step(1, 2, 35'h3BA00477, 32);
        // R11: replace pending abort with access-port access, then R8/R9 acks
        for (int a = 0; a < 8; a++) begin
            step(1, 0, 35'h8, 4);
            step(1, 0, 35'hB, 4);
            step(1, 2, ({$urandom} << 3) | longint'(a), 35);
            step(1, 0, 35'hA, 4);
            idle_cycle();
            step(1, 2, ({$urandom} << 3) | longint'(a), 35);
        end
        // R10: abort clean and dirty
        step(1, 0, 35'h8, 4);
        step(1, 2, 35'h1, 35);
        step(1, 0, 35'h8, 4);
        step(1, 2, 35'h80000000, 35);
        // R3: unknown code waits for shift-out
        step(1, 0, 35'h5, 4);
        step(1, 1, 35'h5, 4);
        step(1, 2, 35'h7_0000_0001, 35);

        // random stream
        for (int i = 0; i < 4000; i++) begin
            int r = int'($urandom_range(0, 9));
            int typ;
            int code;
            rv = {$urandom, $urandom} & 35'h7_FFFF_FFFF;
            if (r < 3) begin
                typ = 0;
                case ($urandom_range(0, 6))
                    0: code = 15; 1: code = 14; 2: code = 10; 3: code = 11;
                    4: code = 8;  default: code = int'($urandom_range(0, 15));
                endcase
                rv = (rv & ~longint'(15)) | longint'(code);
            end else if (r < 5) begin
                typ = 1;
            end else if (r < 8) begin
                typ = 2;
                if ($urandom_range(0, 2) == 0) rv = rv & 35'h7_0000_0001;
            end else begin
                typ = 3;
            end
            step($urandom_range(0, 4) != 0, typ, rv, int'($urandom_range(1, 35)));
        end

        // R1: reset mid-transaction clears pending instruction
        step(1, 0, 35'hA, 4);
        rst = 1'b1;
        idle_cycle();
        rst = 1'b0;
        mstate = 0;
        step(1, 2, 35'h1234, 35);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule